// File: doc/BRIEF.md
# Dual-Edge GPIO Interrupt Status Unit

This unit watches six general-purpose input pins. Each pin can be switched into a dual-edge mode. In that mode, rising and falling transitions both set sticky status bits. Every pin has three status bits: one for the power-management event (PME) path, one for the system-management interrupt (SMI) path, and one in a summary register that gathers all six pins in a single word. Each status bit is set on any edge, whether or not its interrupt is enabled and whether or not dual-edge mode is selected. Software clears a status bit by writing one to it.

The pins are sampled through a two-flop synchroniser. An edge is found by comparing the synchronised level with its value one clock earlier. The PME and SMI request outputs are levels. Each request is high while any pin has its status bit pending, its enable bit set and dual-edge mode selected.

Software also sets per-pin polarity, direction and output-type bits. In dual-edge mode, direction and output type are forced inactive at the pad-control outputs. Polarity then only inverts the level that software reads back from the pin-level register.

The register interface has a 4-bit address and a 6-bit data word. Writes take effect on the clock edge. Reads are combinational.

Top module: `dualedge_irq`

## Requirements
- R1: After reset, every register reads zero, both request outputs are low, and both pad-control outputs are zero.
- R2: A rising edge on a pin sets that pin's bit in the PME status register (address 6), the SMI status register (address 7) and the summary status register (address 8). Bit i belongs to pin i.
- R3: A falling edge on a pin sets the same three status bits as a rising edge.
- R4: Status bits are set regardless of the PME enable (address 4), the SMI enable (address 5) and the mode-select register (address 0, 1 = dual-edge).
- R5: Writing a status register clears each bit written as 1 and leaves bits written as 0 unchanged. Such a write does not affect the other two status registers.
- R6: If an edge on a pin reaches its status bit in the same clock as a write-one-to-clear of that bit, the bit stays set.
- R7: pmeReq is high when, for some pin, the PME status bit, the PME enable bit and the mode-select bit are all 1. smiReq follows the same rule with the SMI status and SMI enable bits. Neither request is raised for a pin whose mode-select bit is 0.
- R8: The pin-level register (address 9) returns the synchronised pin levels XOR the polarity register (address 1), whatever the mode.
- R9: pinOutEn equals the direction register (address 2) with the mode-select bits masked off. pinOpenDrain equals the output-type register (address 3) with the mode-select bits masked off.
- R10: A pin change first shows in the status registers on the third rising clock edge after the change.
- R11: Registers 0 to 5 read back the last value written to them, and change only when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 6 | Asynchronous pin levels |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 6 | Write data, one bit per pin |
| regRdData | output | 6 | Combinational read data |
| pinOutEn | output | 6 | Output-enable control to the pads |
| pinOpenDrain | output | 6 | Open-drain select to the pads |
| pmeReq | output | 1 | Power-management event request level |
| smiReq | output | 1 | System-management interrupt request level |

## Verification
The bench uses the default build: six pins and a 4-bit address. With this build every pin's bit can be driven and checked in one 6-bit word. Each table vector toggles a different mix of pins, in both directions, under different mode and enable masks. This shows status setting apart from request gating. Directed tests place a clear write on the exact cycle an edge arrives, count the synchroniser latency edge by edge, and toggle polarity and mode to check the pin-level read-back and the pad-control masking.

// File: rtl/dualedge_pkg.sv
package dualedge_pkg;
  parameter int PIN_CNT = 6;
  parameter int ADDR_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_MODE    = 4'd0,
    ADDR_POL     = 4'd1,
    ADDR_DIR     = 4'd2,
    ADDR_OTYPE   = 4'd3,
    ADDR_PME_EN  = 4'd4,
    ADDR_SMI_EN  = 4'd5,
    ADDR_PME_STS = 4'd6,
    ADDR_SMI_STS = 4'd7,
    ADDR_SUM_STS = 4'd8,
    ADDR_LEVEL   = 4'd9
  } reg_addr_e;

  typedef struct packed {
    logic [PIN_CNT-1:0] clrPme;
    logic [PIN_CNT-1:0] clrSmi;
    logic [PIN_CNT-1:0] clrSum;
  } clr_strobe_t;
endpackage

// File: rtl/dualedge_sync.sv
module dualedge_sync #(
  parameter int Stages = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [Stages-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[Stages-2:0], asyncIn};
  end

  assign syncOut = chain[Stages-1];
endmodule

// File: rtl/dualedge_ctrl.sv
module dualedge_ctrl
  import dualedge_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [PIN_CNT-1:0] regWrData,
  output logic [PIN_CNT-1:0] regRdData,
  output clr_strobe_t        strb,
  output logic [PIN_CNT-1:0] modeBits,
  output logic [PIN_CNT-1:0] polBits,
  output logic [PIN_CNT-1:0] dirBits,
  output logic [PIN_CNT-1:0] otypeBits,
  output logic [PIN_CNT-1:0] pmeEnBits,
  output logic [PIN_CNT-1:0] smiEnBits,
  input  logic [PIN_CNT-1:0] pmeSts,
  input  logic [PIN_CNT-1:0] smiSts,
  input  logic [PIN_CNT-1:0] sumSts,
  input  logic [PIN_CNT-1:0] pinLvl
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeBits  <= '0;
      polBits   <= '0;
      dirBits   <= '0;
      otypeBits <= '0;
      pmeEnBits <= '0;
      smiEnBits <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_MODE:   modeBits  <= regWrData;
        ADDR_POL:    polBits   <= regWrData;
        ADDR_DIR:    dirBits   <= regWrData;
        ADDR_OTYPE:  otypeBits <= regWrData;
        ADDR_PME_EN: pmeEnBits <= regWrData;
        ADDR_SMI_EN: smiEnBits <= regWrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    if (regWrEn) begin
      case (regAddr)
        ADDR_PME_STS: strb.clrPme = regWrData;
        ADDR_SMI_STS: strb.clrSmi = regWrData;
        ADDR_SUM_STS: strb.clrSum = regWrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_MODE:    regRdData = modeBits;
      ADDR_POL:     regRdData = polBits;
      ADDR_DIR:     regRdData = dirBits;
      ADDR_OTYPE:   regRdData = otypeBits;
      ADDR_PME_EN:  regRdData = pmeEnBits;
      ADDR_SMI_EN:  regRdData = smiEnBits;
      ADDR_PME_STS: regRdData = pmeSts;
      ADDR_SMI_STS: regRdData = smiSts;
      ADDR_SUM_STS: regRdData = sumSts;
      ADDR_LEVEL:   regRdData = pinLvl ^ polBits;
      default:      regRdData = '0;
    endcase
  end

  // R11: mode register only moves on a write to its address
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_MODE) |=> $stable(modeBits));
endmodule

// File: rtl/dualedge_dp.sv
module dualedge_dp
  import dualedge_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIN_CNT-1:0] pinIn,
  input  clr_strobe_t        strb,
  input  logic [PIN_CNT-1:0] modeBits,
  input  logic [PIN_CNT-1:0] pmeEnBits,
  input  logic [PIN_CNT-1:0] smiEnBits,
  output logic [PIN_CNT-1:0] pmeSts,
  output logic [PIN_CNT-1:0] smiSts,
  output logic [PIN_CNT-1:0] sumSts,
  output logic [PIN_CNT-1:0] pinLvl,
  output logic               pmeReq,
  output logic               smiReq
);
  logic [PIN_CNT-1:0] lvlPrev;
  logic [PIN_CNT-1:0] edgeVec;

  for (genvar p = 0; p < PIN_CNT; p++) begin : g_sync
    dualedge_sync #(.Stages(2)) u_sync (
      .clk     (clk),
      .rstN    (rstN),
      .asyncIn (pinIn[p]),
      .syncOut (pinLvl[p])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lvlPrev <= '0;
    else       lvlPrev <= pinLvl;
  end

  assign edgeVec = pinLvl ^ lvlPrev;

  // an edge wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pmeSts <= '0;
      smiSts <= '0;
      sumSts <= '0;
    end else begin
      pmeSts <= (pmeSts & ~strb.clrPme) | edgeVec;
      smiSts <= (smiSts & ~strb.clrSmi) | edgeVec;
      sumSts <= (sumSts & ~strb.clrSum) | edgeVec;
    end
  end

  assign pmeReq = |(pmeSts & pmeEnBits & modeBits);
  assign smiReq = |(smiSts & smiEnBits & modeBits);

  // R2 R3 R6: every detected edge lands in all three status words
  assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    (edgeVec != '0) |=> ((pmeSts & smiSts & sumSts & $past(edgeVec)) == $past(edgeVec)));

  // R2: a status bit never rises without an edge
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((pmeSts & ~$past(pmeSts) & ~$past(edgeVec)) == '0));

  // R5: a status bit only falls after a clear strobe for it
  assert_clear_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    (($past(pmeSts) & ~pmeSts & ~$past(strb.clrPme)) == '0));

  // R7: no request while every pin is out of dual-edge mode
  assert_req_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits == '0) |-> (!pmeReq && !smiReq));
endmodule

// File: rtl/dualedge_irq.sv
module dualedge_irq
  import dualedge_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIN_CNT-1:0] pinIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [PIN_CNT-1:0] regWrData,
  output logic [PIN_CNT-1:0] regRdData,
  output logic [PIN_CNT-1:0] pinOutEn,
  output logic [PIN_CNT-1:0] pinOpenDrain,
  output logic               pmeReq,
  output logic               smiReq
);
  clr_strobe_t        strb;
  logic [PIN_CNT-1:0] modeBits, polBits, dirBits, otypeBits, pmeEnBits, smiEnBits;
  logic [PIN_CNT-1:0] pmeSts, smiSts, sumSts, pinLvl;

  dualedge_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strb      (strb),
    .modeBits  (modeBits),
    .polBits   (polBits),
    .dirBits   (dirBits),
    .otypeBits (otypeBits),
    .pmeEnBits (pmeEnBits),
    .smiEnBits (smiEnBits),
    .pmeSts    (pmeSts),
    .smiSts    (smiSts),
    .sumSts    (sumSts),
    .pinLvl    (pinLvl)
  );

  dualedge_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .strb      (strb),
    .modeBits  (modeBits),
    .pmeEnBits (pmeEnBits),
    .smiEnBits (smiEnBits),
    .pmeSts    (pmeSts),
    .smiSts    (smiSts),
    .sumSts    (sumSts),
    .pinLvl    (pinLvl),
    .pmeReq    (pmeReq),
    .smiReq    (smiReq)
  );

  // R9: dual-edge mode overrides direction and output type
  assign pinOutEn     = dirBits & ~modeBits;
  assign pinOpenDrain = otypeBits & ~modeBits;
endmodule

// File: tb/dualedge_irq_tb.sv
module dualedge_irq_tb;
  localparam time CYC = 20ns;

  typedef struct packed {
    logic [5:0] mode;
    logic [5:0] pmeEn;
    logic [5:0] smiEn;
    logic [5:0] pins;
    logic [5:0] expSts;
    logic       expPme;
    logic       expSmi;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{6'h3F, 6'h01, 6'h02, 6'h03, 6'h03, 1'b1, 1'b1},
    '{6'h00, 6'h3F, 6'h3F, 6'h01, 6'h02, 1'b0, 1'b0},
    '{6'h3C, 6'h0F, 6'h30, 6'h3E, 6'h3F, 1'b1, 1'b1},
    '{6'h3F, 6'h00, 6'h00, 6'h3E, 6'h00, 1'b0, 1'b0},
    '{6'h20, 6'h20, 6'h00, 6'h1E, 6'h20, 1'b1, 1'b0},
    '{6'h01, 6'h02, 6'h01, 6'h1D, 6'h03, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] pinIn = '0;
  logic [3:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [5:0] regWrData = '0;
  logic [5:0] regRdData, pinOutEn, pinOpenDrain;
  logic       pmeReq, smiReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CYC/2) clk = ~clk;

  dualedge_irq u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .pinOutEn(pinOutEn), .pinOpenDrain(pinOpenDrain),
    .pmeReq(pmeReq), .smiReq(smiReq)
  );

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [5:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [5:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [5:0] d;
    rstN = 1'b0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      check("R1 reg", d, 6'h00);
    end
    check("R1 pmeReq/smiReq", {4'b0, pmeReq, smiReq}, 6'h00);
    check("R1 pinOutEn", pinOutEn, 6'h00);
    check("R1 pinOpenDrain", pinOpenDrain, 6'h00);

    // R2 R3 R4 R7 table walk
    foreach (VEC[k]) begin
      wr(4'd6, 6'h3F); wr(4'd7, 6'h3F); wr(4'd8, 6'h3F);
      wr(4'd0, VEC[k].mode); wr(4'd4, VEC[k].pmeEn); wr(4'd5, VEC[k].smiEn);
      pinIn = VEC[k].pins;
      waitCyc(4);
      rd(4'd6, d); check("R2/R3/R4 pme status", d, VEC[k].expSts);
      rd(4'd7, d); check("R2/R3/R4 smi status", d, VEC[k].expSts);
      rd(4'd8, d); check("R2/R3/R4 summary status", d, VEC[k].expSts);
      check("R7 pmeReq", {5'b0, pmeReq}, {5'b0, VEC[k].expPme});
      check("R7 smiReq", {5'b0, smiReq}, {5'b0, VEC[k].expSmi});
    end

    // R11 readback, upper config registers
    wr(4'd0, 6'h15); rd(4'd0, d); check("R11 mode readback", d, 6'h15);
    wr(4'd4, 6'h2A); rd(4'd4, d); check("R11 pme enable readback", d, 6'h2A);
    rd(4'd0, d); check("R11 mode unchanged", d, 6'h15);

    // R8 level readback: pins now 1D
    wr(4'd1, 6'h00); rd(4'd9, d); check("R8 level no polarity", d, 6'h1D);
    wr(4'd1, 6'h0F); rd(4'd9, d); check("R8 level inverted mode 15", d, 6'h12);
    wr(4'd0, 6'h00); rd(4'd9, d); check("R8 level inverted mode 0", d, 6'h12);
    wr(4'd1, 6'h00);

    // R9 pad control masking
    wr(4'd2, 6'h3F); wr(4'd3, 6'h0F);
    check("R9 outEn mode0", pinOutEn, 6'h3F);
    check("R9 openDrain mode0", pinOpenDrain, 6'h0F);
    wr(4'd0, 6'h05);
    check("R9 outEn mode05", pinOutEn, 6'h3A);
    check("R9 openDrain mode05", pinOpenDrain, 6'h0A);

    // R5 write-one-to-clear: make all statuses 3F
    pinIn = ~pinIn; waitCyc(4);
    rd(4'd6, d); check("R5 precondition", d, 6'h3F);
    wr(4'd6, 6'h05); rd(4'd6, d); check("R5 clear ones", d, 6'h3A);
    wr(4'd6, 6'h00); rd(4'd6, d); check("R5 zeros keep", d, 6'h3A);
    rd(4'd7, d); check("R5 smi untouched", d, 6'h3F);
    rd(4'd8, d); check("R5 summary untouched", d, 6'h3F);

    // R10 latency: clear all, toggle pin 2
    wr(4'd6, 6'h3F);
    @(negedge clk); pinIn[2] = ~pinIn[2];
    @(negedge clk); rd(4'd6, d); check("R10 after edge 1", d, 6'h00);
    @(negedge clk); rd(4'd6, d); check("R10 after edge 2", d, 6'h00);
    @(negedge clk); rd(4'd6, d); check("R10 after edge 3", d, 6'h04);

    // R6 edge coinciding with clear: bits 0,1 set, clear 03, edge on pin 0
    wr(4'd6, 6'h3F);
    @(negedge clk); pinIn[1:0] = ~pinIn[1:0];
    waitCyc(4);
    rd(4'd6, d); check("R6 precondition", d, 6'h03);
    @(negedge clk); pinIn[0] = ~pinIn[0];
    @(negedge clk);
    @(negedge clk);
    regAddr = 4'd6; regWrData = 6'h03; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
    rd(4'd6, d); check("R6 edge beats clear", d, 6'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CYC * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule